// File: doc/BRIEF.md
# Tree Leading-Zero Counter

This block turns an indicator vector, such as the output of a leading-one anticipator beside a significand adder, into the binary distance to its first asserted bit. A normalization shifter then uses that distance. Bit 0 of the input is the most significant position. The count is the index of the lowest-numbered set bit. A separate flag reports an input with no bit set.

The count is not formed by a flat priority encoder. Four-bit leaf encoders each produce a 2-bit position and an OR of their bits. Identical two-way compressors then join neighbouring subtrees, level by level. The upper subtree is the lower-numbered half. At each join:

- The upper subtree's OR selects whose position bits pass through.
- The inverse of that OR becomes the new most significant count bit.

An input width that is not a power of two is zero-extended at its tail to the next power of two, with a minimum of 8. The tree result is captured in one output register, so the outputs follow the input one clock later.

Top module: `lzc_tree_top`

## Requirements
- R1: `zero_o` is 1 exactly when every bit of the input sampled at the previous rising clock edge was 0.
- R2: When the sampled input is not all zero, `count_o` equals the smallest index i with `vec_i[i]` = 1, where index 0 is the most significant position.
- R3: The padding positions from IN_W up to the tree width never count as set bits. An input whose only set bit is at index IN_W-1 gives `count_o` = IN_W-1 and `zero_o` = 0.
- R4: For an all-zero input, `count_o` is all ones: 63 for the default width and 7 for an 8-position tree.
- R5: The outputs change only at a rising clock edge, one cycle after the input. Between edges they keep their previous value.
- R6: While `rst_n` is low, the outputs read `zero_o` = 1 and `count_o` all ones.
- R7: Bits with an index greater than the first set bit have no effect on `count_o`.
- R8: With IN_W = 6, the tree is 8 positions wide and `count_o` is 3 bits wide. Counts match R2 and R4 for every 6-bit input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_i | input | IN_W | Indicator vector; bit 0 is the most significant position |
| count_o | output | CNT_W | Registered index of the first set bit (all ones when none) |
| zero_o | output | 1 | Registered flag: no bit of the sampled vector was set |

## Verification
The assertions check four things on every cycle against the input seen one edge earlier:

- The zero flag agrees with an all-zero input.
- A flagged result carries the all-ones count.
- A non-flagged count lands on a set bit.
- Every position ahead of that count is clear, and the count stays inside the real input width.

Reset values, the one-cycle timing, and the fact that bits after the first one are ignored can only be shown by the bench's scenarios. The same holds for correct behaviour of the smaller padded and unpadded trees. The bench covers these with full sweeps of the 8- and 6-position configurations and with walking single bits that carry random tails.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

    // Smallest power of two not below n, never less than 8 (two leaves).
    function automatic int tree_width(input int n);
        int p;
        p = 8;
        for (int i = 0; i < 31; i++) begin
            if (p < n) p = p * 2;
        end
        return p;
    endfunction

endpackage

// File: rtl/lzc_leaf4.sv
module lzc_leaf4 (
    input  logic [3:0] bits_i,
    output logic [1:0] pos_o,
    output logic       any_o
);

    always_comb begin
        any_o = |bits_i;
        if (bits_i[0])      pos_o = 2'd0;
        else if (bits_i[1]) pos_o = 2'd1;
        else if (bits_i[2]) pos_o = 2'd2;
        else                pos_o = 2'd3;
    end

endmodule

// File: rtl/lzc_merge.sv
module lzc_merge #(
    parameter int PW = 2
) (
    input  logic [PW-1:0] hi_pos_i,
    input  logic          hi_any_i,
    input  logic [PW-1:0] lo_pos_i,
    input  logic          lo_any_i,
    output logic [PW:0]   pos_o,
    output logic          any_o
);

    always_comb begin
        pos_o[PW]     = ~hi_any_i;
        pos_o[PW-1:0] = hi_any_i ? hi_pos_i : lo_pos_i;
        any_o         = hi_any_i | lo_any_i;
    end

endmodule

// File: rtl/lzc_tree.sv
module lzc_tree #(
    parameter int TREE_W = 64,
    localparam int CNT_W  = $clog2(TREE_W),
    localparam int LEAVES = TREE_W / 4,
    localparam int LEVELS = CNT_W - 2
) (
    input  logic [TREE_W-1:0] vec_i,
    output logic [CNT_W-1:0]  pos_o,
    output logic              any_o
);

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int NODES = TREE_W >> (lv + 2);
        logic [lv+1:0] pos [NODES];
        logic          any [NODES];

        if (lv == 0) begin : g_leaf
            for (genvar n = 0; n < NODES; n++) begin : g_n
                lzc_leaf4 u_leaf (
                    .bits_i (vec_i[4*n +: 4]),
                    .pos_o  (pos[n]),
                    .any_o  (any[n])
                );
            end
        end else begin : g_join
            for (genvar n = 0; n < NODES; n++) begin : g_n
                lzc_merge #(.PW(lv + 1)) u_merge (
                    .hi_pos_i (g_lvl[lv-1].pos[2*n]),
                    .hi_any_i (g_lvl[lv-1].any[2*n]),
                    .lo_pos_i (g_lvl[lv-1].pos[2*n+1]),
                    .lo_any_i (g_lvl[lv-1].any[2*n+1]),
                    .pos_o    (pos[n]),
                    .any_o    (any[n])
                );
            end
        end
    end

    assign pos_o = g_lvl[LEVELS].pos[0];
    assign any_o = g_lvl[LEVELS].any[0];

endmodule

// File: rtl/lzc_tree_top.sv
module lzc_tree_top #(
    parameter int IN_W = 56,
    localparam int TREE_W = lzc_pkg::tree_width(IN_W),
    localparam int CNT_W  = $clog2(TREE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  vec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             zero;
    } res_t;

    logic [TREE_W-1:0] padded;
    logic [CNT_W-1:0]  tree_pos;
    logic              tree_any;
    res_t              res_d, res_q;

    assign padded = TREE_W'(vec_i);

    lzc_tree #(.TREE_W(TREE_W)) u_tree (
        .vec_i (padded),
        .pos_o (tree_pos),
        .any_o (tree_any)
    );

    always_comb begin
        res_d       = res_q;
        res_d.count = tree_pos;
        res_d.zero  = ~tree_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q.count <= '1;
            res_q.zero  <= 1'b1;
        end else begin
            res_q <= res_d;
        end
    end

    assign count_o = res_q.count;
    assign zero_o  = res_q.zero;

    p_zero_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_q.zero == ($past(vec_i) == '0)));

    p_first_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q.zero |-> ((($past(vec_i) >> res_q.count) & IN_W'(1)) == IN_W'(1)));

    p_prefix_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q.zero |-> (($past(vec_i) << (IN_W - int'(res_q.count))) == '0));

    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q.zero |-> (int'(res_q.count) < IN_W));

    p_zero_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.zero |-> (&res_q.count));

endmodule

// File: tb/lzc_tree_top_bench.sv
module lzc_tree_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [55:0] v56 = '0;
    logic [7:0]  v8 = '0;
    logic [5:0]  v6 = '0;
    logic [5:0]  c56;
    logic [2:0]  c8, c6;
    logic        z56, z8, z6;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    lzc_tree_top u_lzc_tree_top (
        .clk(clk), .rst_n(rst_n), .vec_i(v56), .count_o(c56), .zero_o(z56)
    );

    lzc_tree_top #(.IN_W(8)) u_lzc_tree_top_w8 (
        .clk(clk), .rst_n(rst_n), .vec_i(v8), .count_o(c8), .zero_o(z8)
    );

    lzc_tree_top #(.IN_W(6)) u_lzc_tree_top_w6 (
        .clk(clk), .rst_n(rst_n), .vec_i(v6), .count_o(c6), .zero_o(z6)
    );

    function automatic int first_one(input logic [63:0] v, input int w, input int none);
        for (int i = 0; i < w; i++) begin
            if (v[i]) return i;
        end
        return none;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; result checked at the next falling edge.
    task automatic apply(input logic [55:0] a, input logic [7:0] b, input logic [5:0] c,
                         input string tag56);
        v56 = a; v8 = b; v6 = c;
        @(negedge clk);
        check({tag56, " count w56"}, int'(c56), first_one(64'(a), 56, 63));
        check("R1 zero w56", int'(z56), int'(a == '0));
        check((b == '0) ? "R4 count w8" : "R2 count w8", int'(c8), first_one(64'(b), 8, 7));
        check("R1 zero w8", int'(z8), int'(b == '0));
        check("R8 count w6", int'(c6), first_one(64'(c), 6, 7));
        check("R8 zero w6", int'(z6), int'(c == '0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: reset values
        check("R6 count w56", int'(c56), 63);
        check("R6 zero w56", int'(z56), 1);
        check("R6 count w8", int'(c8), 7);
        check("R6 zero w6", int'(z6), 1);
        rst_n = 1'b1;

        // R5: held until the edge, then updated
        v56 = 56'd1 << 10;
        #5;
        check("R5 count held", int'(c56), 63);
        check("R5 zero held", int'(z56), 1);
        @(negedge clk);
        check("R5 count updated", int'(c56), 10);

        // R4: all-zero input
        apply('0, '0, '0, "R4");

        // R3: only the last real position set
        apply(56'd1 << 55, 8'h80, 6'h20, "R3");

        // R2 / R8: exhaustive sweep of small trees, shifted copies on the wide one
        for (int i = 0; i < 256; i++) begin
            apply(56'(i) << (i % 48), 8'(i), 6'(i), "R2");
        end

        // R7: walking first bit with random tails behind it
        for (int p = 0; p < 56; p++) begin
            for (int k = 0; k < 3; k++) begin
                logic [55:0] tail;
                tail = {$urandom, $urandom} & ~((56'd1 << p) - 56'd1);
                tail[p] = 1'b1;
                apply(tail, 8'($urandom), 6'($urandom), "R7");
            end
        end

        // R2: random wide vectors, some sparse
        for (int i = 0; i < 1500; i++) begin
            logic [55:0] r;
            r = {$urandom, $urandom};
            if (i % 3 == 0) r = r & {$urandom, $urandom} & {$urandom, $urandom};
            if (i % 5 == 0) r = r >> ($urandom % 56);
            apply(r, 8'($urandom), 6'($urandom), "R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule